// File: doc/BRIEF.md
# Memory Self-Test Pattern Engine

The block exercises a synchronous single-port memory on its own and reports whether every location held the data written to it. After a start pulse it writes a chosen stress pattern across the whole address range. It then reads each location back and compares the returned word with the value it wrote. A failing read records the address and the bit-wise difference in a small log. The log can then show which location and which data lines are faulty.

Four patterns are available, each aimed at a fault class:
- a single 1 that rotates across the data bits, for stuck-at and coupling faults;
- a single 0 that rotates the same way;
- an alternating bit pattern, followed by a second pass with its complement, so that as many bits as possible switch together and every cell sees both values;
- a pattern built from the address bits, which catches decoder faults where two addresses share one cell.

The controller is a five-state machine:
- `ST_IDLE` waits for start.
- `ST_WRITE` issues one write per cycle.
- `ST_READ` issues one read per cycle.
- `ST_DRAIN` lets the last read come back and be compared.
- `ST_DONE` holds the result.

It has six transitions:
- IDLE→WRITE on start.
- WRITE→READ after the last address.
- READ→DRAIN after the last address.
- DRAIN→WRITE for the complement pass of the alternating pattern.
- DRAIN→DONE otherwise.
- DONE→WRITE on a new start.

Top module: `mbist_engine`

## Requirements
- R1: After reset, `busy`, `done`, `pass`, `mem_we`, `mem_re`, `log_count` and `log_ovf` are all 0.
- R2: A run writes every address once in ascending order, starting at 0. It then reads every address once in ascending order. `mem_we` and `mem_re` are never high together. The alternating pattern runs this write/read pair twice, and the other patterns run it once.
- R3: With `pat_sel`=0 the write data has only bit (addr mod DATA_W) set.
- R4: With `pat_sel`=1 the write data has only bit (addr mod DATA_W) clear.
- R5: With `pat_sel`=2 the first pass writes 0xAA (odd bit positions set) at even addresses and 0x55 at odd addresses. The second pass writes the bitwise complement of those values.
- R6: With `pat_sel`=3, data bit i equals address bit (i mod ADDR_W). For 8-bit data and a 4-bit address this is {addr,addr}.
- R7: Each read whose data differs from the expected word is a failure. The first LOG_DEPTH failures are logged in order with their address and XOR mask, and `log_count` never exceeds LOG_DEPTH. `log_sel`=k presents entry k on `log_addr` and `log_mask`.
- R8: A failure that arrives while the log is full sets `log_ovf`, which stays set until the next run starts.
- R9: When the run ends, `done` rises and stays high until a new start. `pass` is high only while `done` is high and no failure was seen.
- R10: `start` is ignored while `busy` is high. A start taken in IDLE or DONE latches `pat_sel` and clears the log and the overflow flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begin a run (taken in IDLE or DONE) |
| pat_sel | input | 2 | Pattern: 0 rotating one, 1 rotating zero, 2 alternating, 3 address |
| busy | output | 1 | Run in progress |
| done | output | 1 | Run finished, result valid |
| pass | output | 1 | Finished with no mismatch |
| mem_we | output | 1 | Memory write strobe |
| mem_re | output | 1 | Memory read strobe; data returns one cycle later |
| mem_addr | output | ADDR_W | Memory address |
| mem_wdata | output | DATA_W | Memory write data |
| mem_rdata | input | DATA_W | Memory read data, registered by the memory |
| log_sel | input | clog2(LOG_DEPTH) | Log entry to present |
| log_count | output | clog2(LOG_DEPTH+1) | Number of logged failures |
| log_ovf | output | 1 | More failures than log entries |
| log_addr | output | ADDR_W | Address of selected entry |
| log_mask | output | DATA_W | XOR mismatch mask of selected entry |

## Verification
The assertions assume that the memory returns read data exactly one cycle after `mem_re` and that reset is applied before the first start. The bench memory model keeps that one-cycle latency, and the bench holds reset low for several edges. Faults are injected only in the bench memory: stuck bits on the read path and an aliased write address. The engine's inputs are changed only on falling edges. A start issued while busy comes from a deliberate directed test, which checks that the run continues unchanged.

// File: rtl/mbist_pkg.sv
package mbist_pkg;

    typedef enum logic [1:0] {
        PAT_WALK1 = 2'd0,
        PAT_WALK0 = 2'd1,
        PAT_CHECK = 2'd2,
        PAT_ADDR  = 2'd3
    } pat_e;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_WRITE,
        ST_READ,
        ST_DRAIN,
        ST_DONE
    } state_e;

endpackage

// File: rtl/mbist_patgen.sv
module mbist_patgen
    import mbist_pkg::*;
#(
    parameter int ADDR_W = 4,
    parameter int DATA_W = 8
) (
    input  pat_e              pat,
    input  logic              inv,
    input  logic [ADDR_W-1:0] addr,
    output logic [DATA_W-1:0] data
);

    localparam int ROT_W = (DATA_W > 1) ? $clog2(DATA_W) : 1;

    logic [DATA_W-1:0] walk;
    logic [DATA_W-1:0] chk;
    logic [DATA_W-1:0] adr;
    int unsigned       pos;

    always_comb begin
        pos = int'(addr) % DATA_W;
        for (int i = 0; i < DATA_W; i++) begin
            walk[i] = (pos == i);
            chk[i]  = ((i % 2) == 1) ^ addr[0] ^ inv;
            adr[i]  = addr[i % ADDR_W];
        end
    end

    always_comb begin
        unique case (pat)
            PAT_WALK1: data = walk;
            PAT_WALK0: data = ~walk;
            PAT_CHECK: data = chk;
            PAT_ADDR:  data = adr;
            default:   data = '0;
        endcase
    end

    logic [ROT_W-1:0] unused_rot;
    assign unused_rot = '0;

endmodule

// File: rtl/mbist_ctrl.sv
module mbist_ctrl
    import mbist_pkg::*;
#(
    parameter int ADDR_W = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [1:0]        pat_sel,
    output pat_e              pat_q,
    output logic              inv,
    output logic [ADDR_W-1:0] addr,
    output logic              we,
    output logic              re,
    output logic              busy,
    output logic              done,
    output logic              clr
);

    localparam logic [ADDR_W-1:0] LAST_A = {ADDR_W{1'b1}};

    state_e st, st_nx;
    logic   go;
    logic   last;

    assign go   = start && (st == ST_IDLE || st == ST_DONE);
    assign last = (addr == LAST_A);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st <= ST_IDLE;
        else        st <= st_nx;
    end

    always_comb begin
        st_nx = st;
        unique case (st)
            ST_IDLE:  if (go) st_nx = ST_WRITE;
            ST_WRITE: if (last) st_nx = ST_READ;
            ST_READ:  if (last) st_nx = ST_DRAIN;
            ST_DRAIN: st_nx = (pat_q == PAT_CHECK && !inv) ? ST_WRITE : ST_DONE;
            ST_DONE:  if (go) st_nx = ST_WRITE;
            default:  st_nx = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            addr  <= '0;
            inv   <= 1'b0;
            pat_q <= PAT_WALK1;
        end else if (go) begin
            addr  <= '0;
            inv   <= 1'b0;
            pat_q <= pat_e'(pat_sel);
        end else if (st == ST_WRITE || st == ST_READ) begin
            addr <= last ? '0 : addr + 1'b1;
        end else if (st == ST_DRAIN && st_nx == ST_WRITE) begin
            inv <= 1'b1;
        end
    end

    always_comb begin
        we   = (st == ST_WRITE);
        re   = (st == ST_READ);
        busy = (st == ST_WRITE || st == ST_READ || st == ST_DRAIN);
        done = (st == ST_DONE);
        clr  = go;
    end

    AST_ADDR_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        ((st == ST_WRITE || st == ST_READ) && !last) |=> (addr == $past(addr) + 1'b1)); // R2
    AST_INV_ONLY_CHECK: assert property (@(posedge clk) disable iff (!rst_n)
        inv |-> (pat_q == PAT_CHECK)); // R5
    AST_BUSY_DONE_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
        !(busy && done)); // R9

endmodule

// File: rtl/mbist_log.sv
module mbist_log #(
    parameter int ADDR_W    = 4,
    parameter int DATA_W    = 8,
    parameter int LOG_DEPTH = 4
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         clr,
    input  logic                         chk_valid,
    input  logic [ADDR_W-1:0]            chk_addr,
    input  logic [DATA_W-1:0]            chk_mask,
    input  logic [$clog2(LOG_DEPTH)-1:0] sel,
    output logic [$clog2(LOG_DEPTH+1)-1:0] count,
    output logic                         ovf,
    output logic [ADDR_W-1:0]            sel_addr,
    output logic [DATA_W-1:0]            sel_mask
);

    localparam int CNT_W = $clog2(LOG_DEPTH + 1);
    localparam logic [CNT_W-1:0] FULL = CNT_W'(LOG_DEPTH);

    logic                        fail;
    logic                        room;
    logic [LOG_DEPTH*ADDR_W-1:0] a_flat;
    logic [LOG_DEPTH*DATA_W-1:0] m_flat;

    assign fail = chk_valid && (chk_mask != '0);
    assign room = (count < FULL);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            count <= '0;
            ovf   <= 1'b0;
        end else if (clr) begin
            count <= '0;
            ovf   <= 1'b0;
        end else if (fail) begin
            if (room) count <= count + 1'b1;
            else      ovf   <= 1'b1;
        end
    end

    for (genvar g = 0; g < LOG_DEPTH; g++) begin : g_ent
        logic [ADDR_W-1:0] e_addr;
        logic [DATA_W-1:0] e_mask;
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                e_addr <= '0;
                e_mask <= '0;
            end else if (!clr && fail && count == CNT_W'(g)) begin
                e_addr <= chk_addr;
                e_mask <= chk_mask;
            end
        end
        assign a_flat[g*ADDR_W +: ADDR_W] = e_addr;
        assign m_flat[g*DATA_W +: DATA_W] = e_mask;
    end

    always_comb begin
        sel_addr = '0;
        sel_mask = '0;
        if (int'(sel) < LOG_DEPTH) begin
            sel_addr = a_flat[int'(sel)*ADDR_W +: ADDR_W];
            sel_mask = m_flat[int'(sel)*DATA_W +: DATA_W];
        end
    end

    AST_CNT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        count <= FULL); // R7
    AST_OVF_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (ovf && !clr) |=> ovf); // R8
    AST_OVF_ONLY_FULL: assert property (@(posedge clk) disable iff (!rst_n)
        ovf |-> (count == FULL)); // R8

endmodule

// File: rtl/mbist_engine.sv
module mbist_engine
    import mbist_pkg::*;
#(
    parameter int ADDR_W    = 4,
    parameter int DATA_W    = 8,
    parameter int LOG_DEPTH = 4
) (
    input  logic                           clk,
    input  logic                           rst_n,
    input  logic                           start,
    input  logic [1:0]                     pat_sel,
    output logic                           busy,
    output logic                           done,
    output logic                           pass,
    output logic                           mem_we,
    output logic                           mem_re,
    output logic [ADDR_W-1:0]              mem_addr,
    output logic [DATA_W-1:0]              mem_wdata,
    input  logic [DATA_W-1:0]              mem_rdata,
    input  logic [$clog2(LOG_DEPTH)-1:0]   log_sel,
    output logic [$clog2(LOG_DEPTH+1)-1:0] log_count,
    output logic                           log_ovf,
    output logic [ADDR_W-1:0]              log_addr,
    output logic [DATA_W-1:0]              log_mask
);

    pat_e              pat_q;
    logic              inv;
    logic              clr;
    logic [DATA_W-1:0] gen_data;
    logic              cmp_v;
    logic [ADDR_W-1:0] cmp_a;
    logic [DATA_W-1:0] cmp_exp;
    logic [DATA_W-1:0] diff;

    mbist_ctrl #(.ADDR_W(ADDR_W)) u_ctrl (
        .clk(clk), .rst_n(rst_n), .start(start), .pat_sel(pat_sel),
        .pat_q(pat_q), .inv(inv), .addr(mem_addr), .we(mem_we), .re(mem_re),
        .busy(busy), .done(done), .clr(clr)
    );

    mbist_patgen #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_gen (
        .pat(pat_q), .inv(inv), .addr(mem_addr), .data(gen_data)
    );

    assign mem_wdata = gen_data;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cmp_v   <= 1'b0;
            cmp_a   <= '0;
            cmp_exp <= '0;
        end else begin
            cmp_v   <= mem_re;
            cmp_a   <= mem_addr;
            cmp_exp <= gen_data;
        end
    end

    assign diff = mem_rdata ^ cmp_exp;

    mbist_log #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .LOG_DEPTH(LOG_DEPTH)) u_log (
        .clk(clk), .rst_n(rst_n), .clr(clr), .chk_valid(cmp_v),
        .chk_addr(cmp_a), .chk_mask(diff), .sel(log_sel),
        .count(log_count), .ovf(log_ovf), .sel_addr(log_addr), .sel_mask(log_mask)
    );

    assign pass = done && (log_count == '0);

    AST_WE_RE_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
        !(mem_we && mem_re)); // R2
    AST_WALK1_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_we && pat_q == PAT_WALK1) |-> ($countones(mem_wdata) == 1)); // R3
    AST_WALK0_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_we && pat_q == PAT_WALK0) |-> ($countones(~mem_wdata) == 1)); // R4
    AST_PASS_NEEDS_DONE: assert property (@(posedge clk) disable iff (!rst_n)
        pass |-> done); // R9
    AST_START_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && start) |=> (pat_q == $past(pat_q))); // R10

endmodule

// File: tb/sim_mbist_engine.sv
module sim_mbist_engine;

    localparam int AW = 4;
    localparam int DW = 8;
    localparam int LD = 4;
    localparam int NA = 1 << AW;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          start = 1'b0;
    logic [1:0]    pat_sel = 2'd0;
    logic          busy, done, pass, mem_we, mem_re, log_ovf;
    logic [AW-1:0] mem_addr, log_addr;
    logic [DW-1:0] mem_wdata, mem_rdata, log_mask;
    logic [1:0]    log_sel = 2'd0;
    logic [2:0]    log_count;

    always #10 clk = ~clk;

    mbist_engine #(.ADDR_W(AW), .DATA_W(DW), .LOG_DEPTH(LD)) u0 (
        .clk(clk), .rst_n(rst_n), .start(start), .pat_sel(pat_sel),
        .busy(busy), .done(done), .pass(pass), .mem_we(mem_we), .mem_re(mem_re),
        .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_rdata(mem_rdata),
        .log_sel(log_sel), .log_count(log_count), .log_ovf(log_ovf),
        .log_addr(log_addr), .log_mask(log_mask)
    );

    int checks = 0;
    int errors = 0;

    // fault kinds: 0 none, 1 stuck-1 on read, 2 stuck-0 on read, 3 write address alias
    logic [1:0]    f_kind = 2'd0;
    logic [AW-1:0] f_addr = '0;
    logic [DW-1:0] f_mask = '0;
    logic          ram_clr = 1'b0;
    logic [1:0]    cur_pat = 2'd0;

    logic [DW-1:0] ram [NA];
    int wr_n, rd_n, wr_bad, rd_bad;

    function automatic logic [DW-1:0] gen(input logic [1:0] p, input int ph, input int a);
        logic [DW-1:0] v;
        logic [3:0]    a4;
        a4 = a[3:0];
        case (p)
            2'd0: v = 8'h01 << (a % DW);
            2'd1: v = ~(8'h01 << (a % DW));
            2'd2: v = ((a % 2) == 1 ? 8'h55 : 8'hAA) ^ (ph != 0 ? 8'hFF : 8'h00);
            default: v = {a4, a4};
        endcase
        return v;
    endfunction

    always @(posedge clk) begin
        if (ram_clr) begin
            for (int i = 0; i < NA; i++) ram[i] <= '0;
            mem_rdata <= '0;
            wr_n <= 0; rd_n <= 0; wr_bad <= 0; rd_bad <= 0;
        end else begin
            if (mem_we) begin
                if (f_kind == 2'd3) ram[mem_addr & ~f_mask[AW-1:0]] <= mem_wdata;
                else                ram[mem_addr] <= mem_wdata;
                if (int'(mem_addr) != wr_n % NA ||
                    mem_wdata != gen(cur_pat, wr_n / NA, int'(mem_addr)))
                    wr_bad <= wr_bad + 1;
                wr_n <= wr_n + 1;
            end
            if (mem_re) begin
                logic [DW-1:0] r;
                r = ram[mem_addr];
                if (f_kind == 2'd1 && mem_addr == f_addr) r = r | f_mask;
                if (f_kind == 2'd2 && mem_addr == f_addr) r = r & ~f_mask;
                mem_rdata <= r;
                if (int'(mem_addr) != rd_n % NA || mem_we) rd_bad <= rd_bad + 1;
                rd_n <= rd_n + 1;
            end
        end
    end

    int            e_cnt;
    logic          e_ovf;
    logic [AW-1:0] e_addr [LD];
    logic [DW-1:0] e_mask [LD];

    task automatic model(input logic [1:0] p, input logic [1:0] k,
                         input logic [AW-1:0] fa, input logic [DW-1:0] fm);
        logic [DW-1:0] mm [NA];
        int np;
        for (int a = 0; a < NA; a++) mm[a] = '0;
        e_cnt = 0; e_ovf = 1'b0;
        np = (p == 2'd2) ? 2 : 1;
        for (int ph = 0; ph < np; ph++) begin
            for (int a = 0; a < NA; a++) begin
                logic [AW-1:0] wa;
                wa = AW'(a);
                if (k == 2'd3) wa = wa & ~fm[AW-1:0];
                mm[wa] = gen(p, ph, a);
            end
            for (int a = 0; a < NA; a++) begin
                logic [DW-1:0] r, x;
                r = mm[a];
                if (k == 2'd1 && AW'(a) == fa) r = r | fm;
                if (k == 2'd2 && AW'(a) == fa) r = r & ~fm;
                x = r ^ gen(p, ph, a);
                if (x != '0) begin
                    if (e_cnt < LD) begin
                        e_addr[e_cnt] = AW'(a);
                        e_mask[e_cnt] = x;
                        e_cnt++;
                    end else e_ovf = 1'b1;
                end
            end
        end
    endtask

    task automatic check(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic run(input logic [1:0] p, input bit poke);
        int n;
        @(negedge clk);
        ram_clr = 1'b1;
        @(negedge clk);
        ram_clr = 1'b0;
        cur_pat = p;
        pat_sel = p;
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        n = 0;
        while (!done && n < 2000) begin
            @(negedge clk);
            n++;
            if (poke && n == 5) begin
                pat_sel = ~p;
                start = 1'b1;
            end else start = 1'b0;
        end
        if (!done) begin
            errors++;
            $display("FAIL R9 watchdog expired actual=0 expected=1");
        end
    endtask

    localparam logic [15:0] VEC [10] = '{
        {2'd0, 2'd0, 4'd0, 8'h00},
        {2'd1, 2'd0, 4'd0, 8'h00},
        {2'd2, 2'd0, 4'd0, 8'h00},
        {2'd3, 2'd0, 4'd0, 8'h00},
        {2'd0, 2'd1, 4'd3, 8'h01},
        {2'd2, 2'd1, 4'd3, 8'h01},
        {2'd1, 2'd2, 4'd5, 8'hFF},
        {2'd3, 2'd3, 4'd0, 8'h04},
        {2'd2, 2'd2, 4'd6, 8'h80},
        {2'd3, 2'd0, 4'd0, 8'h00}
    };

    task automatic check_result(input logic [1:0] p);
        string pr;
        int np;
        pr = (p == 2'd0) ? "R3" : (p == 2'd1) ? "R4" : (p == 2'd2) ? "R5" : "R6";
        np = (p == 2'd2) ? 2 : 1;
        check(pr, wr_bad, 0);
        check("R2 writes", wr_n, NA * np);
        check("R2 reads", rd_n, NA * np);
        check("R2 order", rd_bad, 0);
        check("R9 done", int'(done), 1);
        check("R9 pass", int'(pass), int'(e_cnt == 0));
        check("R7 count", int'(log_count), e_cnt);
        check("R8 ovf", int'(log_ovf), int'(e_ovf));
        for (int i = 0; i < e_cnt; i++) begin
            log_sel = 2'(i);
            #1;
            check("R7 addr", int'(log_addr), int'(e_addr[i]));
            check("R7 mask", int'(log_mask), int'(e_mask[i]));
        end
    endtask

    initial begin
        ram_clr = 1'b1;
        repeat (3) @(negedge clk);
        check("R1 busy", int'(busy), 0);
        check("R1 done", int'(done), 0);
        check("R1 pass", int'(pass), 0);
        check("R1 strobes", int'(mem_we | mem_re), 0);
        check("R1 log", int'(log_count) + int'(log_ovf), 0);
        rst_n = 1'b1;
        ram_clr = 1'b0;
        @(negedge clk);

        for (int v = 0; v < 10; v++) begin
            f_kind = VEC[v][13:12];
            f_addr = VEC[v][11:8];
            f_mask = VEC[v][7:0];
            model(VEC[v][15:14], f_kind, f_addr, f_mask);
            run(VEC[v][15:14], 1'b0);
            check_result(VEC[v][15:14]);
        end

        // R10: start while busy has no effect on pattern or sequence
        f_kind = 2'd0;
        model(2'd0, 2'd0, '0, '0);
        run(2'd0, 1'b1);
        check("R10 busy start", wr_bad, 0);
        check("R10 write count", wr_n, NA);
        check_result(2'd0);

        // R9: done and result hold while idle in done state
        repeat (4) @(negedge clk);
        check("R9 done held", int'(done), 1);
        check("R9 pass held", int'(pass), 1);
        check("R9 no strobes", int'(mem_we | mem_re), 0);

        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule